// File: doc/BRIEF.md
# Rotating-Template Binary Cell Array

This block is a rectangular grid of one-bit cells that all move to a new state together when a global step strobe is high. Each cell's next state is a function of its own bit and its eight surrounding bits. A three-bit operation code picks the rule for the whole grid. The rules are rotated erosion, plain erosion, plain dilation, thinning, erasing isolated dots, and keeping only isolated dots. A per-cell dot flag shows which cells are isolated set pixels.

A two-bit direction counter advances on every step. In rotated erosion, the counter turns the neighbour bits by multiples of 90 degrees before the one-sided template is applied. As a result, an object is trimmed from the north, east, south and west on successive steps. Objects of even width therefore collapse to a single remaining pixel instead of disappearing.

A row port writes an image into the grid and reads it back, one row per clock. Everything outside the grid reads as 0. A controller outside the block sequences the operations and counts the steps.

Top module: `ca_rot_array`

## Requirements
- R1: After reset every cell is 0, `dotMap` is all zero and `dirSel` is 0.
- R2: When `rowWr` is high, `rowIn` is written into row `rowSel` at the clock edge, with bit c holding column c. When `rowRd` is high, that row is copied to `rowOut`, which is valid one cycle later. A write overrides a step for the addressed row.
- R3: While `stepEn` and `rowWr` are low, every cell and `dirSel` keep their values.
- R4: `dirSel` increments modulo 4 on every cycle with `stepEn` high, whatever the operation. Its values mean north (row-1) for 0, east (column+1) for 1, south (row+1) for 2 and west (column-1) for 3.
- R5: Operation 0 is rotated erosion. A set cell that is not a dot is cleared when its neighbour on side `dirSel` is 0. No cell is ever set.
- R6: A dot is a set cell whose eight neighbours are all 0, reported on `dotMap` bit row*COLS+column. Dots survive rotated erosion, so a 2x2 block ends as one pixel.
- R7: Operation 1 is plain erosion. A cell stays 1 only if it and all eight of its neighbours are 1.
- R8: Operation 2 is dilation. A cell becomes 1 if it or any of its eight neighbours is 1.
- R9: Operation 3 is thinning, which clears a set cell that has at least two set neighbours when the template of the current phase matches. On even `dirSel` the template matches when north is 0 and south is 1, or when west is 0 and east is 1. On odd `dirSel` it matches when south is 0 and north is 1, or when east is 0 and west is 1.
- R10: Operation 4 clears exactly the dot cells and leaves every other cell unchanged.
- R11: Operation 5 clears every cell that is not a dot.
- R12: Operation codes 6 and 7 leave every cell unchanged, while `dirSel` still advances.
- R13: Positions outside the grid read as 0, and no rule wraps around the edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepEn | input | 1 | Global step strobe |
| mode | input | 3 | Operation code |
| rowSel | input | $clog2(ROWS) | Row address for load and read |
| rowWr | input | 1 | Row write strobe |
| rowRd | input | 1 | Row read strobe |
| rowIn | input | COLS | Row write data |
| rowOut | output | COLS | Registered row read data |
| dotMap | output | ROWS*COLS | Per-cell dot flags |
| dirSel | output | 2 | Current template direction |

## Verification
The bench runs a 2x2 block and a full grid through rotated erosion. A design that ignored the dot exemption, or rotated the wrong way, would lose the block or leave the wrong survivor. A lone pixel must survive rotated erosion, and erosion or dilation at a corner must treat the outside as zero. A design that wrapped around the edges would set or keep cells on the opposite edge. Thinning checks the phase choice and the guard that protects line ends; a wrong phase leaves the wrong corner of the block set. The dot-erase and dot-keep rules are checked on a mix of isolated pixels and a pair, which catches a dot test that looks at too few neighbours.

// File: rtl/ca_pkg.sv
package ca_pkg;

  // operation codes applied to the whole grid
  typedef enum logic [2:0] {
    OP_ROT_ERODE = 3'd0,
    OP_ERODE     = 3'd1,
    OP_DILATE    = 3'd2,
    OP_THIN      = 3'd3,
    OP_ERASE_DOT = 3'd4,
    OP_KEEP_DOT  = 3'd5,
    OP_NOP6      = 3'd6,
    OP_NOP7      = 3'd7
  } caOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   step;
    logic [1:0] dir;
    caOp_e  op;
  } caCtrl_t;

  // neighbour slot order, clockwise from north
  localparam int NB_N  = 0;
  localparam int NB_NE = 1;
  localparam int NB_E  = 2;
  localparam int NB_SE = 3;
  localparam int NB_S  = 4;
  localparam int NB_SW = 5;
  localparam int NB_W  = 6;
  localparam int NB_NW = 7;

endpackage

// File: rtl/ca_ctrl.sv
module ca_ctrl
  import ca_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepEn,
  input  logic [2:0] mode,
  output caCtrl_t    ctrl,
  output logic [1:0] dirSel
);

  logic [1:0] dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirQ <= 2'd0;
    else if (stepEn) dirQ <= dirQ + 2'd1;
  end

  always_comb begin
    ctrl.step = stepEn;
    ctrl.dir  = dirQ;
    ctrl.op   = caOp_e'(mode);
  end

  assign dirSel = dirQ;

endmodule

// File: rtl/ca_cell.sv
module ca_cell
  import ca_pkg::*;
(
  input  logic       self,
  input  logic [7:0] nb,
  input  caCtrl_t    ctrl,
  output logic       nextState,
  output logic       isDot
);

  // crossbar: rotate the ring so slot 0 faces the current direction
  logic [7:0] rot;
  for (genvar i = 0; i < 8; i++) begin : g_xbar
    always_comb begin
      unique case (ctrl.dir)
        2'd0:    rot[i] = nb[(i + 0) % 8];
        2'd1:    rot[i] = nb[(i + 2) % 8];
        2'd2:    rot[i] = nb[(i + 4) % 8];
        default: rot[i] = nb[(i + 6) % 8];
      endcase
    end
  end

  logic [3:0] nbCount;
  logic       thinHit;

  always_comb begin
    nbCount = '0;
    for (int k = 0; k < 8; k++) nbCount = nbCount + {3'd0, nb[k]};
  end

  always_comb begin
    if (!ctrl.dir[0])
      thinHit = (!nb[NB_N] && nb[NB_S]) || (!nb[NB_W] && nb[NB_E]);
    else
      thinHit = (!nb[NB_S] && nb[NB_N]) || (!nb[NB_E] && nb[NB_W]);
  end

  assign isDot = self && (nb == 8'd0);

  always_comb begin
    unique case (ctrl.op)
      OP_ROT_ERODE: nextState = self && (rot[0] || isDot);
      OP_ERODE:     nextState = self && (&nb);
      OP_DILATE:    nextState = self || (|nb);
      OP_THIN:      nextState = self && !(thinHit && (nbCount >= 4'd2));
      OP_ERASE_DOT: nextState = self && !isDot;
      OP_KEEP_DOT:  nextState = isDot;
      default:      nextState = self;
    endcase
  end

endmodule

// File: rtl/ca_grid.sv
module ca_grid
  import ca_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CELLS = ROWS * COLS
)(
  input  logic             clk,
  input  logic             rstN,
  input  caCtrl_t          ctrl,
  input  logic [RW-1:0]    rowSel,
  input  logic             rowWr,
  input  logic             rowRd,
  input  logic [COLS-1:0]  rowIn,
  output logic [COLS-1:0]  rowOut,
  output logic [CELLS-1:0] dotMap,
  output logic [CELLS-1:0] cellState
);

  logic [CELLS-1:0] stateQ;
  logic [CELLS-1:0] nextVec;
  logic [COLS+1:0]  pad [ROWS+2];

  // zero ring around the live grid
  always_comb begin
    for (int r = 0; r < ROWS + 2; r++) pad[r] = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        pad[r+1][c+1] = stateQ[r*COLS + c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [7:0] nb;
      assign nb[NB_N]  = pad[r][c+1];
      assign nb[NB_NE] = pad[r][c+2];
      assign nb[NB_E]  = pad[r+1][c+2];
      assign nb[NB_SE] = pad[r+2][c+2];
      assign nb[NB_S]  = pad[r+2][c+1];
      assign nb[NB_SW] = pad[r+2][c];
      assign nb[NB_W]  = pad[r+1][c];
      assign nb[NB_NW] = pad[r][c];

      ca_cell u_cell (
        .self      (stateQ[r*COLS + c]),
        .nb        (nb),
        .ctrl      (ctrl),
        .nextState (nextVec[r*COLS + c]),
        .isDot     (dotMap[r*COLS + c])
      );
    end
  end

  // write wins over a step on the addressed row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
    end else begin
      if (ctrl.step) stateQ <= nextVec;
      if (rowWr && (int'(rowSel) < ROWS))
        stateQ[int'(rowSel)*COLS +: COLS] <= rowIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowOut <= '0;
    else if (rowRd && (int'(rowSel) < ROWS))
      rowOut <= stateQ[int'(rowSel)*COLS +: COLS];
  end

  assign cellState = stateQ;

endmodule

// File: rtl/ca_rot_array.sv
module ca_rot_array
  import ca_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CELLS = ROWS * COLS
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepEn,
  input  logic [2:0]       mode,
  input  logic [RW-1:0]    rowSel,
  input  logic             rowWr,
  input  logic             rowRd,
  input  logic [COLS-1:0]  rowIn,
  output logic [COLS-1:0]  rowOut,
  output logic [CELLS-1:0] dotMap,
  output logic [1:0]       dirSel
);

  caCtrl_t          ctrl;
  logic [CELLS-1:0] cellState;

  ca_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stepEn (stepEn),
    .mode   (mode),
    .ctrl   (ctrl),
    .dirSel (dirSel)
  );

  ca_grid #(.ROWS(ROWS), .COLS(COLS)) u_grid (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .rowSel    (rowSel),
    .rowWr     (rowWr),
    .rowRd     (rowRd),
    .rowIn     (rowIn),
    .rowOut    (rowOut),
    .dotMap    (dotMap),
    .cellState (cellState)
  );

endmodule

// File: rtl/ca_rot_array_chk.sv
module ca_rot_array_chk #(
  parameter int CELLS = 64
)(
  input logic             clk,
  input logic             rstN,
  input logic             stepEn,
  input logic             rowWr,
  input logic [2:0]       mode,
  input logic [1:0]       dirSel,
  input logic [CELLS-1:0] dotMap,
  input logic [CELLS-1:0] cellState
);

  // R4: direction advances by one per step
  a_r4_dir_advance: assert property (@(posedge clk) disable iff (!rstN)
    stepEn |=> (dirSel == $past(dirSel) + 2'd1));

  // R3: nothing moves without a step or a write
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !rowWr) |=> ($stable(cellState) && $stable(dirSel)));

  // R5: clearing rules never set a cell
  a_r5_never_set: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !rowWr && (mode inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5}))
      |=> ((cellState & ~$past(cellState)) == '0));

  // R6: dots survive rotated erosion
  a_r6_dot_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !rowWr && (mode == 3'd0))
      |=> (($past(dotMap) & ~cellState) == '0));

  // R8: dilation never clears
  a_r8_grow_only: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !rowWr && (mode == 3'd2))
      |=> (($past(cellState) & ~cellState) == '0));

  // R11: keep-dots leaves exactly the previous dots
  a_r11_keep_dots: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !rowWr && (mode == 3'd5))
      |=> (cellState == $past(dotMap)));

endmodule

bind ca_rot_array ca_rot_array_chk #(.CELLS(ROWS*COLS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stepEn    (stepEn),
  .rowWr     (rowWr),
  .mode      (mode),
  .dirSel    (dirSel),
  .dotMap    (dotMap),
  .cellState (cellState)
);

// File: tb/sim_ca_rot_array.sv
`timescale 1ns/1ps
module sim_ca_rot_array;

  localparam int R = 4;
  localparam int C = 4;
  localparam int NV = 15;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stepEn = 1'b0;
  logic [2:0]   mode = 3'd6;
  logic [1:0]   rowSel = '0;
  logic         rowWr = 1'b0;
  logic         rowRd = 1'b0;
  logic [C-1:0] rowIn = '0;
  logic [C-1:0] rowOut;
  logic [R*C-1:0] dotMap;
  logic [1:0]   dirSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ca_rot_array #(.ROWS(R), .COLS(C)) u0 (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .mode(mode), .rowSel(rowSel),
    .rowWr(rowWr), .rowRd(rowRd), .rowIn(rowIn), .rowOut(rowOut),
    .dotMap(dotMap), .dirSel(dirSel)
  );

  // {mode, steps, image in, expected}; image nibble r = row r, bit c = column c
  localparam logic [42:0] VEC [NV] = '{
    {3'd2, 8'd1, 16'h0020, 16'h0777},  // R8 dilate lone pixel
    {3'd2, 8'd1, 16'h0001, 16'h0033},  // R13 corner dilation, no wrap
    {3'd1, 8'd1, 16'hFFFF, 16'h0660},  // R7 R13 erosion at edges
    {3'd1, 8'd1, 16'h0777, 16'h0020},  // R7
    {3'd1, 8'd1, 16'h0660, 16'h0000},  // R7 even block vanishes
    {3'd0, 8'd4, 16'h0660, 16'h0200},  // R5 R6 even block to one dot
    {3'd0, 8'd4, 16'hFFFF, 16'h0660},  // R5 four sides in order
    {3'd0, 8'd8, 16'hFFFF, 16'h0200},  // R5 R6
    {3'd0, 8'd4, 16'h0020, 16'h0020},  // R6 lone dot survives
    {3'd3, 8'd1, 16'h0660, 16'h0400},  // R9 even phase
    {3'd3, 8'd2, 16'h00F0, 16'h00F0},  // R9 line ends protected
    {3'd4, 8'd1, 16'hC101, 16'hC000},  // R10
    {3'd5, 8'd1, 16'hC101, 16'h0101},  // R11
    {3'd6, 8'd2, 16'h0660, 16'h0660},  // R12
    {3'd7, 8'd1, 16'h0660, 16'h0660}   // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; stepEn = 1'b0; rowWr = 1'b0; rowRd = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic loadImg(input logic [15:0] img);
    for (int r = 0; r < R; r++) begin
      @(negedge clk);
      rowWr = 1'b1; rowSel = 2'(r); rowIn = img[r*C +: C];
    end
    @(negedge clk);
    rowWr = 1'b0;
  endtask

  task automatic readImg(output logic [15:0] img);
    for (int r = 0; r < R; r++) begin
      @(negedge clk);
      rowRd = 1'b1; rowSel = 2'(r);
      @(negedge clk);
      rowRd = 1'b0;
      img[r*C +: C] = rowOut;
    end
  endtask

  task automatic runSteps(input logic [2:0] m, input int n);
    @(negedge clk);
    mode = m; stepEn = 1'b1;
    repeat (n) @(negedge clk);
    stepEn = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] img;
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readImg(img);
    check("R1 image", img, 16'h0000);
    check("R1 dotMap", dotMap, 16'h0000);
    check("R1 dirSel", dirSel, 2'd0);

    // R2 write/read round trip
    loadImg(16'hA5C3);
    readImg(img);
    check("R2 roundtrip", img, 16'hA5C3);

    // R3 hold without step
    repeat (3) @(negedge clk);
    readImg(img);
    check("R3 hold image", img, 16'hA5C3);
    check("R3 hold dirSel", dirSel, 2'd0);

    // R4 direction counter wraps
    runSteps(3'd6, 5);
    check("R4 dirSel after 5 steps", dirSel, 2'd1);

    // R6 dot flags
    doReset();
    loadImg(16'hC101);
    @(negedge clk);
    check("R6 dotMap", dotMap, 16'h0101);

    // table walk
    for (int v = 0; v < NV; v++) begin
      doReset();
      loadImg(VEC[v][31:16]);
      runSteps(VEC[v][42:40], int'(VEC[v][39:32]));
      readImg(img);
      check($sformatf("vector %0d mode %0d (R5-R13 table)", v, VEC[v][42:40]),
            img, VEC[v][15:0]);
    end

    // R12 reserved code still advances direction
    doReset();
    runSteps(3'd7, 2);
    check("R12 dirSel advances", dirSel, 2'd2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule